// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy-Routing Autodetect

This block folds the four interrupt pins (INTA..INTD) of a set of PCI slots onto four system interrupt outputs. Under correct routing each pin is rotated by its slot number plus a fixed per-board offset, the usual PCI swizzle. There are two board variants with different offsets. A legacy routing mode sends every pin of every slot to output 0 instead. That mode exists because some guest software was written for a faulty earlier routing.

The block watches configuration-space writes to decide which routing the software expects. While the mode is still undecided, a write to the interrupt-line register is classified by the slot it targets and the byte written. The result can leave the mode undecided, lock in legacy routing, or lock in correct routing. Once a decision is made it holds until reset. A reset-time strap can force either decision, or leave detection enabled. The forwarding of configuration data to the devices themselves is not part of this block.

Top module: `pci_irq_router`

## Requirements
- R1: During and after reset, until the first configuration decision, `mode_o` equals the strap `init_mode_i` under the encoding 0 = undecided, 1 = legacy, 2 = forced-correct; strap value 3 is treated as 0.
- R2: Once `mode_o` is 1 or 2, no configuration write changes it until the next reset.
- R3: A write changes the mode only when `cfg_we_i` is high, `cfg_addr_i[7:0]` is 0x3C, `variant_b_i` is 0 and the mode is 0; the new mode is visible on `mode_o` after that clock edge.
- R4: With `variant_b_i` = 1 no configuration write ever changes the mode.
- R5: The slot index used for classification is the device number `cfg_addr_i[15:11]` modulo 4, i.e. `cfg_addr_i[12:11]`.
- R6: A written byte of 27 leaves the mode at 0 when the slot index is 2, and sets it to 1 for any other slot index.
- R7: A written byte equal to 27 + slot index, or 91 + slot index, sets the mode to 1.
- R8: Any other written byte sets the mode to 2.
- R9: In modes 0 and 2 with `variant_b_i` = 0, pin p (0 = INTA) of slot number n drives `irq_o[(n + p + 2) mod 4]`; for example slot 31 INTA drives `irq_o[1]`.
- R10: In modes 0 and 2 with `variant_b_i` = 1, pin p of slot n drives `irq_o[(n + p + 3) mod 4]`.
- R11: In mode 1 every asserted pin of every slot drives `irq_o[0]`, and `irq_o[3:1]` stay low.
- R12: Each output is the OR of all pins routed onto it, and is low when none of them is asserted; the outputs follow the pins with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_b_i | input | 1 | Board variant: 0 = variant A (offset 2, autodetect), 1 = variant B (offset 3) |
| init_mode_i | input | 2 | Reset-time mode strap |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 16 | Configuration address: [15:11] device, [10:8] function, [7:0] register offset |
| cfg_wdata_i | input | 8 | Low byte of the configuration write data |
| pin_lvl_i | input | 4*NUM_SLOTS | Pin levels, bit 4*s+p is pin p of slot SLOT_BASE+s |
| irq_o | output | 4 | System interrupt outputs |
| mode_o | output | 2 | Current routing mode |

## Verification
The bench builds the router with NUM_SLOTS = 8 and SLOT_BASE = 28, so slot numbers 28 to 35 are driven. Every residue modulo 4 appears twice, and slot 31 is present for the worked routing example. Device numbers 2 and 6, which share slot index 2, are both reachable for the value-27 exception. Device 9 shows the modulo wrap. Repeated resets with each strap value reach all four initial modes, including the reserved code.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  typedef enum logic [1:0] {
    MODE_UNDECIDED = 2'd0,
    MODE_LEGACY    = 2'd1,
    MODE_CORRECT   = 2'd2
  } route_mode_e;

  localparam logic [7:0] IRQ_LINE_OFF = 8'h3C;
  localparam int unsigned LEGACY_BASE = 27;
  localparam int unsigned LEGACY_BIAS = 64;
  localparam int unsigned OFFSET_A    = 2;
  localparam int unsigned OFFSET_B    = 3;
endpackage

// File: rtl/irq_line_classifier.sv
module irq_line_classifier
  import pci_irq_router_pkg::*;
(
  input  logic [1:0]  slot_idx_i,
  input  logic [7:0]  value_i,
  output route_mode_e verdict_o
);
  localparam logic [7:0] BASE_LO = 8'(LEGACY_BASE);
  localparam logic [7:0] BASE_HI = 8'(LEGACY_BASE + LEGACY_BIAS);

  logic [7:0] slot_ext;
  assign slot_ext = {6'd0, slot_idx_i};

  always_comb begin
    if (value_i == BASE_LO)
      verdict_o = (slot_idx_i == 2'd2) ? MODE_UNDECIDED : MODE_LEGACY;
    else if (value_i == BASE_LO + slot_ext || value_i == BASE_HI + slot_ext)
      verdict_o = MODE_LEGACY;
    else
      verdict_o = MODE_CORRECT;
  end
endmodule

// File: rtl/route_mode_reg.sv
module route_mode_reg
  import pci_irq_router_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  init_mode_i,
  input  logic        detect_i,
  input  route_mode_e verdict_i,
  input  logic [1:0]  slot_idx_i,
  input  logic [7:0]  value_i,
  output route_mode_e mode_o
);
  route_mode_e mode_q, mode_d, strap_mode;
  logic        started_q;

  always_comb begin
    case (init_mode_i)
      2'd1:    strap_mode = MODE_LEGACY;
      2'd2:    strap_mode = MODE_CORRECT;
      default: strap_mode = MODE_UNDECIDED;
    endcase
  end

  // strap holds until the first edge after reset, then the register owns the mode
  assign mode_o = started_q ? mode_q : strap_mode;
  assign mode_d = (detect_i && mode_o == MODE_UNDECIDED) ? verdict_i : mode_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      mode_q    <= MODE_UNDECIDED;
    end else begin
      started_q <= 1'b1;
      mode_q    <= mode_d;
    end
  end

  // R2
  sticky_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_UNDECIDED) |=> (mode_o == $past(mode_o)));

  // R3
  no_detect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !detect_i |=> (mode_o == $past(mode_o)));

  // R6
  slot2_exception_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_i && mode_o == MODE_UNDECIDED && value_i == 8'd27 && slot_idx_i == 2'd2)
      |=> (mode_o == MODE_UNDECIDED));

  // R8
  correct_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_i && mode_o == MODE_UNDECIDED && value_i == 8'd200)
      |=> (mode_o == MODE_CORRECT));
endmodule

// File: rtl/irq_swizzle.sv
module irq_swizzle
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_BASE = 28
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   variant_b_i,
  input  route_mode_e            mode_i,
  input  logic [4*NUM_SLOTS-1:0] pin_lvl_i,
  output logic [3:0]             irq_o
);
  localparam int unsigned PINS = 4;

  logic [3:0] slot_irq [NUM_SLOTS];
  logic       legacy;
  assign legacy = (mode_i == MODE_LEGACY);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      slot_irq[s] = '0;
      for (int p = 0; p < PINS; p++) begin
        if (pin_lvl_i[s*PINS+p]) begin
          if (legacy)
            slot_irq[s][0] = 1'b1;
          else if (variant_b_i)
            slot_irq[s][2'(SLOT_BASE + s + p + OFFSET_B)] = 1'b1;
          else
            slot_irq[s][2'(SLOT_BASE + s + p + OFFSET_A)] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) irq_o |= slot_irq[s];
  end

  // R11
  legacy_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy |-> (irq_o[3:1] == 3'b000 && irq_o[0] == (|pin_lvl_i)));

  // R12
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_lvl_i == '0) |-> (irq_o == 4'b0000));

  // R12
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(irq_o) <= $countones(pin_lvl_i)));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_BASE = 28
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   variant_b_i,
  input  logic [1:0]             init_mode_i,
  input  logic                   cfg_we_i,
  input  logic [15:0]            cfg_addr_i,
  input  logic [7:0]             cfg_wdata_i,
  input  logic [4*NUM_SLOTS-1:0] pin_lvl_i,
  output logic [3:0]             irq_o,
  output logic [1:0]             mode_o
);
  logic [4:0]  dev_num;
  logic [1:0]  slot_idx;
  logic        detect;
  logic [2:0]  unused_func;
  route_mode_e verdict, mode;

  assign dev_num     = cfg_addr_i[15:11];
  assign unused_func = cfg_addr_i[10:8];
  assign slot_idx    = dev_num[1:0];
  assign detect      = cfg_we_i && (cfg_addr_i[7:0] == IRQ_LINE_OFF) && !variant_b_i;

  irq_line_classifier u_classify (
    .slot_idx_i (slot_idx),
    .value_i    (cfg_wdata_i),
    .verdict_o  (verdict)
  );

  route_mode_reg u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_mode_i (init_mode_i),
    .detect_i    (detect),
    .verdict_i   (verdict),
    .slot_idx_i  (slot_idx),
    .value_i     (cfg_wdata_i),
    .mode_o      (mode)
  );

  irq_swizzle #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BASE (SLOT_BASE)
  ) u_swizzle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .variant_b_i (variant_b_i),
    .mode_i      (mode),
    .pin_lvl_i   (pin_lvl_i),
    .irq_o       (irq_o)
  );

  assign mode_o = mode;

  // R4
  variant_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    variant_b_i |=> (mode_o == $past(mode_o)));
endmodule

// File: tb/pci_irq_router_tb.sv
`timescale 1ns/1ps
module pci_irq_router_tb;
  localparam int NS = 8;
  localparam int SB = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          var_b = 1'b0;
  logic [1:0]    init_mode = 2'd0;
  logic          we = 1'b0;
  logic [15:0]   addr = '0;
  logic [7:0]    wdata = '0;
  logic [4*NS-1:0] pins = '0;
  logic [3:0]    irq;
  logic [1:0]    mode;

  int n_checks = 0;
  int n_fails  = 0;
  int m_mode   = 0;
  bit m_started = 0;

  always #2.5 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS), .SLOT_BASE(SB)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .variant_b_i (var_b), .init_mode_i (init_mode),
    .cfg_we_i (we), .cfg_addr_i (addr), .cfg_wdata_i (wdata), .pin_lvl_i (pins),
    .irq_o (irq), .mode_o (mode)
  );

  function automatic int strap_val(logic [1:0] v);
    return (v == 2'd3) ? 0 : int'(v);
  endfunction

  function automatic int eff_mode();
    return m_started ? m_mode : strap_val(init_mode);
  endfunction

  function automatic int classify(int slot4, int val);
    if (val == 27) return (slot4 == 2) ? 0 : 1;
    if (val == 27 + slot4 || val == 91 + slot4) return 1;
    return 2;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (pins[4*s+p]) begin
          if (eff_mode() == 1) r[0] = 1'b1;
          else r[(SB + s + p + (var_b ? 3 : 2)) % 4] = 1'b1;
        end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_started <= 0;
      m_mode    <= 0;
    end else begin
      int cur;
      cur = eff_mode();
      if (we && addr[7:0] == 8'h3C && !var_b && cur == 0)
        m_mode <= classify(int'(addr[12:11]), int'(wdata));
      else
        m_mode <= cur;
      m_started <= 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // cycle compare against the behavioural model
  always @(negedge clk) begin
    check("R1 R2 mode track", int'(mode), eff_mode());
    check(var_b ? "R10 route" : "R9 route", int'(irq), int'(exp_irq()));
  end

  task automatic do_reset(logic [1:0] strap);
    @(posedge clk); #1;
    rst_n = 1'b0; init_mode = strap;
    @(negedge clk);
    check("R1 strap in reset", int'(mode), strap_val(strap));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strap after reset", int'(mode), strap_val(strap));
  endtask

  task automatic cfg_write(int dev, logic [7:0] off, logic [7:0] val, logic strobe);
    @(posedge clk); #1;
    we = strobe; addr = {5'(dev), 3'd0, off}; wdata = val;
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
  endtask

  task automatic random_pins(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      pins = $urandom();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset(2'd0);
    check("R12 idle outputs", int'(irq), 0);

    // R9 worked example: slot 31 INTA -> irq 1
    @(posedge clk); #1; pins = '0; pins[4*3+0] = 1'b1;
    @(negedge clk); check("R9 slot31 INTA", int'(irq), 4'b0010);
    // R12 two pins merge on output 2
    @(posedge clk); #1; pins = '0; pins[0] = 1'b1; pins[4*1+3] = 1'b1;
    @(negedge clk); check("R12 or merge", int'(irq), 4'b0100);
    random_pins(30);
    // R10 variant B
    @(posedge clk); #1; var_b = 1'b1; pins = '0; pins[4*3+0] = 1'b1;
    @(negedge clk); check("R10 slot31 INTA", int'(irq), 4'b0100);
    random_pins(30);
    // R4 variant B ignores a legacy-looking write
    cfg_write(0, 8'h3C, 8'd27, 1'b1);
    check("R4 variant B no detect", int'(mode), 0);
    @(posedge clk); #1; var_b = 1'b0;
    // R3 wrong offset and missing strobe
    cfg_write(1, 8'h3D, 8'd28, 1'b1);
    check("R3 other offset", int'(mode), 0);
    cfg_write(1, 8'h3C, 8'd28, 1'b0);
    check("R3 no strobe", int'(mode), 0);
    // R6 slot index 2 exception, devices 2 and 6
    cfg_write(2, 8'h3C, 8'd27, 1'b1);
    check("R6 dev2 value 27", int'(mode), 0);
    cfg_write(6, 8'h3C, 8'd27, 1'b1);
    check("R6 dev6 value 27", int'(mode), 0);
    // R7 27+slot
    cfg_write(5, 8'h3C, 8'd28, 1'b1);
    check("R7 dev5 value 28", int'(mode), 1);
    @(posedge clk); #1; pins = '0; pins[4*2+1] = 1'b1; pins[4*6+3] = 1'b1;
    @(negedge clk); check("R11 legacy route", int'(irq), 4'b0001);
    random_pins(20);
    cfg_write(0, 8'h3C, 8'd99, 1'b1);
    check("R2 legacy sticks", int'(mode), 1);

    do_reset(2'd0);
    cfg_write(3, 8'h3C, 8'd27, 1'b1);
    check("R6 dev3 value 27", int'(mode), 1);

    do_reset(2'd0);
    cfg_write(7, 8'h3C, 8'd94, 1'b1);
    check("R7 dev7 value 94", int'(mode), 1);

    do_reset(2'd0);
    cfg_write(9, 8'h3C, 8'd28, 1'b1);
    check("R5 dev9 wraps to slot 1", int'(mode), 1);

    do_reset(2'd0);
    cfg_write(1, 8'h3C, 8'd29, 1'b1);
    check("R8 dev1 value 29", int'(mode), 2);
    cfg_write(0, 8'h3C, 8'd27, 1'b1);
    check("R2 correct sticks", int'(mode), 2);
    random_pins(20);

    do_reset(2'd0);
    cfg_write(4, 8'h3C, 8'd200, 1'b1);
    check("R8 value 200", int'(mode), 2);

    do_reset(2'd1);
    random_pins(10);
    do_reset(2'd2);
    random_pins(10);
    do_reset(2'd3);
    cfg_write(0, 8'h3C, 8'd91, 1'b1);
    check("R7 dev0 value 91", int'(mode), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule